// File: doc/BRIEF.md
# Gen2 Stuck-Link Recovery Monitor

This block watches a PCIe link for a stall during the speed change to Gen2 and clears the stall by pulsing receiver overrides in the PHY. Its inputs are two 32-bit PHY debug words and the PHY receive-valid bit. It checks them at a programmable interval. The stall it looks for has three parts: link training is no longer flagged as busy, receive-valid is low, and the LTSSM is parked in Recovery.RcvrLock. When it finds that stall, it runs a read-modify-write sequence on the PHY receive-override register through a simple request/acknowledge register port. That port can be wired to the PHY handshake master.

The first read-modify-write sets the receive-data-enable and receive-PLL-enable override bits. The block then holds the overrides for a fixed number of clock cycles, about 2 to 3 ms at the system clock rate. A second read-modify-write clears the two bits again and leaves every other bit of the register as it was. A flag shows that a pulse is in progress, and a saturating counter records how many pulses have completed. A registered link-up output mirrors the training-busy bit.

Top module: `stuck_link_recovery`

## Requirements
- R1: After reset, `reg_req`, `recov_busy`, `link_up` and `recov_count` are all 0.
- R2: `link_up` equals the inverse of bit 4 of `dbg_hi`, one clock cycle later.
- R3: A pulse starts only on a check tick in which all three hold: `dbg_hi[4]` is 0, `rx_valid` is 0, and `dbg_lo[5:0]` equals 6'h0D. Every other bit of both debug words is ignored.
- R4: A check causes no register transfer and leaves `recov_count` unchanged in each of these cases: `dbg_hi[4]` is 1, `rx_valid` is 1, or `dbg_lo[5:0]` is not 6'h0D.
- R5: A pulse makes exactly four transfers, all to address 16'h1005: a read; a write of the value read OR 16'h0028 (bits 5 and 3); a second read; and a write of that second value AND NOT 16'h0028.
- R6: Between the completion of the set-write and the clearing read, `reg_req` stays low for exactly HOLD_CYCLES clock cycles.
- R7: A transfer completes on a cycle in which `reg_req` and `reg_ack` are both 1. Until then, `reg_req`, `reg_we`, `reg_addr` and `reg_wdata` stay stable.
- R8: `recov_busy` goes high in the cycle of the first read request and falls when the clearing write completes.
- R9: `recov_count` increases by one for each completed pulse and holds at its all-ones maximum.
- R10: Checks are made only while no pulse is in progress. After a pulse ends, the next check comes after `chk_interval`+1 idle cycles, so a stall that persists is re-pulsed after exactly that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_interval | input | IVL_W | Idle cycles between checks, minus one |
| dbg_lo | input | 32 | First PHY debug word; bits 5:0 hold the LTSSM state |
| dbg_hi | input | 32 | Second PHY debug word; bit 4 means training busy |
| rx_valid | input | 1 | PHY receive-valid |
| reg_req | output | 1 | Register transfer request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 16 | PHY register address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Transfer acknowledge |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| link_up | output | 1 | Link trained indication |
| recov_busy | output | 1 | Recovery pulse in progress |
| recov_count | output | CNT_W | Saturating count of completed pulses |

## Verification
The bench aims at the trigger boundaries. It tries each single condition that must suppress a pulse, a state code of 0x0C that sits next to 0x0D, and debug words with every unrelated bit set. A design that decoded too many or too few bits would either pulse when it should not or miss the stall. Read data is chosen both with the override bits clear and with every bit set. A design that wrote constants instead of merging with the read value, or that cleared the wrong bits, would break the compared write data. The bench measures the hold gap and the re-check gap against HOLD_CYCLES and `chk_interval`+1, which catches counters that are off by one cycle. Five pulses drive a 2-bit counter past its limit, so a counter that wraps to 0 instead of saturating is caught.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [15:0] OVRD_ADDR   = 16'h1005;
  localparam logic [15:0] OVRD_MASK   = 16'h0028;  // rx data enable (bit 5) | rx PLL enable (bit 3)
  localparam logic [5:0]  ST_RCVRLOCK = 6'h0D;
  localparam int          BUSY_BIT    = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_SET, S_WR_SET, S_HOLD, S_RD_CLR, S_WR_CLR
  } stk_state_e;

  function automatic logic f_stuck(input logic [31:0] lo, input logic [31:0] hi,
                                   input logic rxv);
    return !hi[BUSY_BIT] && !rxv && (lo[5:0] == ST_RCVRLOCK);
  endfunction

  function automatic logic [15:0] f_set(input logic [15:0] v);
    return v | OVRD_MASK;
  endfunction

  function automatic logic [15:0] f_clr(input logic [15:0] v);
    return v & ~OVRD_MASK;
  endfunction
endpackage

// File: rtl/stk_pacer.sv
module stk_pacer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IVL_W-1:0] limit,
  output logic             tick
);
  logic [IVL_W-1:0] cnt;

  assign tick = en && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!en)      cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/stk_detect.sv
module stk_detect (
  input  logic [31:0] dbg_lo,
  input  logic [31:0] dbg_hi,
  input  logic        rx_valid,
  output logic        stuck
);
  import stk_pkg::*;
  assign stuck = f_stuck(dbg_lo, dbg_hi, rx_valid);
endmodule

// File: rtl/stk_satcnt.sv
module stk_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (inc && count != MAXV)   count <= count + 1'b1;
  end

  // R9: the count only ever moves up by one
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == $past(count) + 1'b1));
  // R9: the count holds at its maximum
  p_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (count == MAXV));
endmodule

// File: rtl/stuck_link_recovery.sv
module stuck_link_recovery #(
  parameter int IVL_W       = 16,
  parameter int HOLD_CYCLES = 250000,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IVL_W-1:0] chk_interval,
  input  logic [31:0]      dbg_lo,
  input  logic [31:0]      dbg_hi,
  input  logic             rx_valid,
  output logic             reg_req,
  output logic             reg_we,
  output logic [15:0]      reg_addr,
  output logic [15:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [15:0]      reg_rdata,
  output logic             link_up,
  output logic             recov_busy,
  output logic [CNT_W-1:0] recov_count
);
  import stk_pkg::*;

  localparam int              HOLD_W    = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  stk_state_e        state;
  logic [15:0]       shadow;
  logic [HOLD_W-1:0] hold_cnt;
  logic              chk_tick, stuck_now, xfer_done, pulse_done, idle;

  assign idle       = (state == S_IDLE);
  assign xfer_done  = reg_req && reg_ack;
  assign pulse_done = (state == S_WR_CLR) && xfer_done;
  assign recov_busy = !idle;

  assign reg_req   = (state == S_RD_SET) || (state == S_WR_SET) ||
                     (state == S_RD_CLR) || (state == S_WR_CLR);
  assign reg_we    = (state == S_WR_SET) || (state == S_WR_CLR);
  assign reg_addr  = OVRD_ADDR;
  assign reg_wdata = reg_we ? shadow : 16'h0000;

  stk_pacer #(.IVL_W(IVL_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(idle), .limit(chk_interval), .tick(chk_tick)
  );

  stk_detect u_detect (
    .dbg_lo(dbg_lo), .dbg_hi(dbg_hi), .rx_valid(rx_valid), .stuck(stuck_now)
  );

  stk_satcnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(pulse_done), .count(recov_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_up <= 1'b0;
    else        link_up <= !dbg_hi[BUSY_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      shadow   <= '0;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        S_IDLE:   if (chk_tick && stuck_now) state <= S_RD_SET;
        S_RD_SET: if (xfer_done) begin
                    shadow <= f_set(reg_rdata);
                    state  <= S_WR_SET;
                  end
        S_WR_SET: if (xfer_done) begin
                    hold_cnt <= '0;
                    state    <= S_HOLD;
                  end
        S_HOLD:   if (hold_cnt == HOLD_LAST) state <= S_RD_CLR;
                  else hold_cnt <= hold_cnt + 1'b1;
        S_RD_CLR: if (xfer_done) begin
                    shadow <= f_clr(reg_rdata);
                    state  <= S_WR_CLR;
                  end
        S_WR_CLR: if (xfer_done) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R2: link indication follows the training-busy bit one cycle later
  p_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (link_up == !$past(dbg_hi[BUSY_BIT])));
  // R7: a pending request holds its fields until acknowledged
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr)
                               && $stable(reg_wdata)));
  // R3: a pulse only starts from a detected stall
  p_start_stuck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_busy) |-> $past(stuck_now));
  // R10: a pulse only starts on a pacer tick
  p_start_paced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_busy) |-> $past(chk_tick));
  // R5: the set-write carries both override bits
  p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_SET) |-> ((reg_wdata & OVRD_MASK) == OVRD_MASK));
  // R5: the clear-write carries neither override bit
  p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_CLR) |-> ((reg_wdata & OVRD_MASK) == 16'h0000));
endmodule

// File: tb/stuck_link_recovery_tb.sv
module stuck_link_recovery_tb;
  localparam int IVL_W = 8;
  localparam int HOLD  = 20;
  localparam int CNT_W = 2;
  localparam int IVL   = 5;

  typedef struct packed { logic we; logic [15:0] addr; logic [15:0] data; } txn_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IVL_W-1:0] chk_interval = IVL_W'(IVL);
  logic [31:0] dbg_lo = 32'h11, dbg_hi = 32'h10;
  logic rx_valid = 1'b0;
  logic reg_req, reg_we, reg_ack = 1'b0;
  logic [15:0] reg_addr, reg_wdata, reg_rdata = 16'h0;
  logic link_up, recov_busy;
  logic [CNT_W-1:0] recov_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0, pace_chk = 0;
  txn_t exp_q[$];
  logic [15:0] mem = 16'h12C7;     // slave register contents
  logic [15:0] model = 16'h12C7;   // driver-side expectation

  always #5 clk = ~clk;

  stuck_link_recovery #(.IVL_W(IVL_W), .HOLD_CYCLES(HOLD), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_interval(chk_interval), .dbg_lo(dbg_lo),
    .dbg_hi(dbg_hi), .rx_valid(rx_valid), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .link_up(link_up), .recov_busy(recov_busy),
    .recov_count(recov_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // driver: expected transfers of one pulse
  task automatic push_recovery();
    logic [15:0] s;
    s = model | 16'h0028;
    exp_q.push_back('{1'b0, 16'h1005, 16'h0});
    exp_q.push_back('{1'b1, 16'h1005, s});
    exp_q.push_back('{1'b0, 16'h1005, 16'h0});
    model = s & ~16'h0028;
    exp_q.push_back('{1'b1, 16'h1005, model});
  endtask

  // slave + scoreboard monitor
  int nh = 0, wcnt = 0, wr_idx = 0, gap = 0, kind = 0;
  bit armed = 0;
  always @(negedge clk) begin
    bit dropped;
    txn_t e;
    dropped = 0;
    if (reg_ack) begin reg_ack = 1'b0; wcnt = 0; dropped = 1; end
    if (armed) begin
      if (reg_req) begin
        armed = 0;
        if (kind == 1) chk(gap == HOLD, "R6 hold gap", gap, HOLD);
        else if (pace_chk) chk(gap == IVL + 1, "R10 recheck gap", gap, IVL + 1);
      end else gap++;
    end
    if (!dropped && reg_req) begin
      if (wcnt >= nh % 3) begin
        reg_ack = 1'b1;
        reg_rdata = mem;
        nh++;
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected transfer", {reg_we, reg_addr}, 0);
        end else begin
          e = exp_q.pop_front();
          chk(reg_we == e.we && reg_addr == e.addr, "R5 kind/addr",
              {reg_we, reg_addr}, {e.we, e.addr});
          if (e.we) chk(reg_wdata == e.data, "R5 write data", reg_wdata, e.data);
        end
        if (reg_we) begin
          mem = reg_wdata;
          wr_idx++;
          kind = (wr_idx % 2 == 1) ? 1 : 2;
          armed = 1;
          gap = 0;
        end
      end else wcnt++;
    end
  end

  task automatic run_pulse(input string tag);
    for (int i = 0; i < 3000 && !recov_busy; i++) @(negedge clk);
    chk(recov_busy && reg_req, {tag, " R8 busy with first request"}, recov_busy, 1);
    for (int i = 0; i < 3000 && recov_busy; i++) @(negedge clk);
    chk(!recov_busy, {tag, " R8 busy falls"}, recov_busy, 0);
  endtask

  task automatic quiet(input string tag);
    repeat (60) @(negedge clk);
    chk(recov_count == 0 && !recov_busy, tag, recov_count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!reg_req && !recov_busy, "R1 req/busy", {reg_req, recov_busy}, 0);
    chk(!link_up, "R1 link_up", link_up, 0);
    chk(recov_count == 0, "R1 count", recov_count, 0);
    rst_n = 1'b1;

    dbg_hi = 32'h0; @(negedge clk);
    chk(link_up == 1'b1, "R2 link up", link_up, 1);
    dbg_hi = 32'h10; @(negedge clk);
    chk(link_up == 1'b0, "R2 link down", link_up, 0);

    dbg_lo = 32'h0D; dbg_hi = 32'h10; rx_valid = 1'b0;
    quiet("R4 training busy");
    dbg_hi = 32'h0; rx_valid = 1'b1;
    quiet("R4 rx_valid high");
    rx_valid = 1'b0; dbg_lo = 32'h0C;
    quiet("R4 state 0x0C");

    push_recovery();
    dbg_lo = 32'h0D;
    run_pulse("R3 basic");
    dbg_lo = 32'h11;
    chk(recov_count == 1, "R9 count after one", recov_count, 1);

    mem = 16'hFFFF; model = 16'hFFFF;
    push_recovery();
    dbg_lo = 32'hFFFF_FFCD; dbg_hi = 32'hFFFF_FFEF;
    run_pulse("R3 upper bits ignored");
    dbg_lo = 32'h11;
    chk(recov_count == 2, "R9 count after two", recov_count, 2);

    pace_chk = 1;
    dbg_hi = 32'h0;
    push_recovery(); push_recovery(); push_recovery();
    dbg_lo = 32'h0D;
    for (int k = 0; k < 3; k++) run_pulse("R10 back-to-back");
    dbg_lo = 32'h11;
    repeat (40) @(negedge clk);
    chk(recov_count == 3, "R9 saturated", recov_count, 3);
    chk(exp_q.size() == 0, "R5 all transfers seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule